// File: doc/BRIEF.md
# Descriptor-Ring DMA Sequencer

This block moves data between host memory and a local buffer RAM. A ring of 256 descriptor elements in host memory controls the transfers. Software first writes the ring's base address. It then writes a count of elements to process. For each element the sequencer takes these steps in order:

1. It reads the four-word element from host memory.
2. It moves the requested bytes one 32-bit word at a time, in the direction the element selects.
3. It may hand a new write pointer to a downstream packet-ready queue.
4. It may raise a sticky interrupt.
5. It retires the element and advances its ring index.

Both memories are reached through simple request ports. A request is held with valid until ready, and a read returns a separate response strobe with data. Only one request is outstanding at a time. The packet-queue update is a one-cycle write strobe with a value. Completion and interrupt status are level outputs that software clears by writing ones.

Top module: `dle_dma_seq`

## Requirements
- R1: Element i of the ring sits at host byte address base + 16*i. Its words are laid out as follows:
  - offset 0: host byte address.
  - offset 4: local byte address, in bits 23:0.
  - offset 8: byte count, in bits 16:0.
  - offset 12: mode in bits 15:0 and the new queue pointer in bits 31:16.
- R2: The registers are selected by `reg_addr`: 0 is the ring base, 1 is the element count and 2 is the status clear. A nonzero count written while idle starts processing. A count of zero leaves the block idle.
- R3: With mode bit 2 clear, ceil(count/4) words are copied from host to local. Both addresses step by 4 per word. No word past that number is touched.
- R4: With mode bit 2 set, the same number of words is copied from local to host.
- R5: With mode bit 0 clear, `qptr_wr_o` pulses for exactly one cycle after the element's data moves, carrying the element's new pointer value. With the bit set, no pulse occurs.
- R6: With mode bit 1 set, `irq_o` is set when the element retires. It stays set until status bit 0 is written with one.
- R7: `elem_idx_o` steps by one per retired element and wraps from 255 to 0.
- R8: `remain_o` drops by one per retired element. When it reaches zero, the block goes idle and `done_o` sets. Status bit 1 written with one clears `done_o`.
- R9: A byte count of zero retires the element with no data request. The queue update and the interrupt still follow the mode bits.
- R10: A count write while busy adds to the remaining count.
- R11: A memory request keeps valid, address and write flag stable until ready is seen.
- R12: After reset the block is idle, with index 0, remaining count 0, `irq_o` and `done_o` low, and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 count, 2 status clear |
| reg_wdata | input | 32 | Register write data |
| hm_req_valid | output | 1 | Host request valid |
| hm_req_ready | input | 1 | Host request accepted |
| hm_req_write | output | 1 | Host request is a write |
| hm_req_addr | output | 32 | Host byte address |
| hm_req_wdata | output | 32 | Host write data |
| hm_rsp_valid | input | 1 | Host read data valid |
| hm_rsp_data | input | 32 | Host read data |
| lb_req_valid | output | 1 | Local request valid |
| lb_req_ready | input | 1 | Local request accepted |
| lb_req_write | output | 1 | Local request is a write |
| lb_req_addr | output | 24 | Local byte address |
| lb_req_wdata | output | 32 | Local write data |
| lb_rsp_valid | input | 1 | Local read data valid |
| lb_rsp_data | input | 32 | Local read data |
| qptr_wr_o | output | 1 | Packet-queue write pointer load strobe |
| qptr_val_o | output | 16 | New packet-queue write pointer |
| irq_o | output | 1 | Sticky interrupt |
| done_o | output | 1 | Sticky completion flag |
| busy_o | output | 1 | Sequencer is processing |
| elem_idx_o | output | 8 | Ring index of the next element |
| remain_o | output | 16 | Elements still to process |

## Verification
The assertions check the following on every cycle:
- The request-hold rule on both memory ports.
- The ring index moves only by +1.
- The remaining count falls by exactly one whenever it changes without a count write.
- The queue strobe lasts a single cycle.
- The interrupt rises only together with an element retirement.
- Completion appears only with the sequencer idle.

Only the bench scenarios can show the rest. These are the word counts and their rounding, the copy directions and the untouched neighbour words, and the zero-length elements. They also cover the cumulative count written mid-run, the index wrap after a long run, and the clear-by-writing-one behaviour.

// File: rtl/dle_dma_pkg.sv
package dle_dma_pkg;
  localparam int HADDR_W = 32;
  localparam int LADDR_W = 24;
  localparam int BCNT_W  = 17;
  localparam int PTR_W   = 16;
  localparam int DATA_W  = 32;

  localparam int MODE_NOQ = 0;
  localparam int MODE_IRQ = 1;
  localparam int MODE_DIR = 2;

  localparam logic [1:0] REG_BASE  = 2'd0;
  localparam logic [1:0] REG_COUNT = 2'd1;
  localparam logic [1:0] REG_STAT  = 2'd2;

  typedef struct packed {
    logic [HADDR_W-1:0] haddr;
    logic [LADDR_W-1:0] laddr;
    logic [BCNT_W-1:0]  bytes;
    logic [15:0]        mode;
    logic [PTR_W-1:0]   new_ptr;
  } dle_elem_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_FETCH, SEQ_MOVE, SEQ_RETIRE} seq_state_e;
  typedef enum logic [1:0] {FT_IDLE, FT_REQ, FT_WAIT} fetch_state_e;
  typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_RWAIT, MV_WR} move_state_e;
endpackage

// File: rtl/dle_ring_ctrl.sv
module dle_ring_ctrl
  import dle_dma_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  input  logic               retire_i,
  input  logic               retire_irq_i,
  output logic [HADDR_W-1:0] base_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [CNT_W-1:0]   remain_o,
  output logic               done_o,
  output logic               irq_o
);
  logic [HADDR_W-1:0] base_q;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [CNT_W-1:0]   remain_q, remain_d, add_val;
  logic               done_q, done_d, irq_q, irq_d;
  logic               base_en, cnt_wr, stat_wr, cnt_en;

  always_comb begin
    base_en  = reg_wr_en_i && (reg_addr_i == REG_BASE);
    cnt_wr   = reg_wr_en_i && (reg_addr_i == REG_COUNT);
    stat_wr  = reg_wr_en_i && (reg_addr_i == REG_STAT);
    add_val  = cnt_wr ? reg_wdata_i[CNT_W-1:0] : '0;
    cnt_en   = cnt_wr || retire_i;
    remain_d = remain_q - CNT_W'(retire_i) + add_val;
    idx_d    = idx_q + IDX_W'(1);

    done_d = done_q;
    if (retire_i && (remain_q == CNT_W'(1)) && (add_val == '0))
      done_d = 1'b1;
    else if (stat_wr && reg_wdata_i[1])
      done_d = 1'b0;
    else if (add_val != '0)
      done_d = 1'b0;

    irq_d = irq_q;
    if (retire_i && retire_irq_i)
      irq_d = 1'b1;
    else if (stat_wr && reg_wdata_i[0])
      irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= reg_wdata_i[HADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= '0;
    else if (retire_i) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain_q <= '0;
    else if (cnt_en) remain_q <= remain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      irq_q  <= irq_d;
    end
  end

  assign base_o   = base_q;
  assign idx_o    = idx_q;
  assign remain_o = remain_q;
  assign done_o   = done_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/dle_elem_fetch.sv
module dle_elem_fetch
  import dle_dma_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int ELEM_WORDS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [HADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               req_valid_o,
  output logic [HADDR_W-1:0] req_addr_o,
  input  logic               req_ready_i,
  input  logic               rsp_valid_i,
  input  logic [DATA_W-1:0]  rsp_data_i,
  output dle_elem_t          elem_o,
  output logic               done_o
);
  localparam int ELEM_SHIFT = $clog2(ELEM_WORDS * 4);
  localparam int WCNT_W     = (ELEM_WORDS > 1) ? $clog2(ELEM_WORDS) : 1;

  fetch_state_e             st_q, st_d;
  logic [WCNT_W-1:0]        wcnt_q, wcnt_d;
  logic                     done_q, done_d;
  logic [ELEM_WORDS-1:0][DATA_W-1:0] words_q;
  logic                     cap_en, last_word;
  logic [HADDR_W-1:0]       elem_base;

  always_comb begin
    elem_base = base_i + (HADDR_W'(idx_i) << ELEM_SHIFT);
    last_word = (wcnt_q == WCNT_W'(ELEM_WORDS - 1));
    cap_en    = (st_q == FT_WAIT) && rsp_valid_i;
    st_d      = st_q;
    wcnt_d    = wcnt_q;
    done_d    = 1'b0;
    case (st_q)
      FT_IDLE: if (start_i) begin
        st_d   = FT_REQ;
        wcnt_d = '0;
      end
      FT_REQ: if (req_ready_i) st_d = FT_WAIT;
      FT_WAIT: if (rsp_valid_i) begin
        if (last_word) begin
          st_d   = FT_IDLE;
          done_d = 1'b1;
        end else begin
          st_d   = FT_REQ;
          wcnt_d = wcnt_q + WCNT_W'(1);
        end
      end
      default: st_d = FT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FT_IDLE;
      wcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      done_q <= done_d;
    end
  end

  for (genvar w = 0; w < ELEM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words_q[w] <= '0;
      else if (cap_en && (wcnt_q == WCNT_W'(w)))
        words_q[w] <= rsp_data_i;
    end
  end

  assign req_valid_o   = (st_q == FT_REQ);
  assign req_addr_o    = elem_base + (HADDR_W'(wcnt_q) << 2);
  assign done_o        = done_q;
  assign elem_o.haddr   = words_q[0][HADDR_W-1:0];
  assign elem_o.laddr   = words_q[1][LADDR_W-1:0];
  assign elem_o.bytes   = words_q[2][BCNT_W-1:0];
  assign elem_o.mode    = words_q[3][15:0];
  assign elem_o.new_ptr = words_q[3][31:16];
endmodule

// File: rtl/dle_word_mover.sv
module dle_word_mover
  import dle_dma_pkg::*;
#(
  parameter int WCNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               dir_i,
  input  logic [HADDR_W-1:0] haddr_i,
  input  logic [LADDR_W-1:0] laddr_i,
  input  logic [WCNT_W-1:0]  nwords_i,
  output logic               h_valid_o,
  output logic               h_write_o,
  output logic [HADDR_W-1:0] h_addr_o,
  output logic [DATA_W-1:0]  h_wdata_o,
  input  logic               h_ready_i,
  input  logic               h_rsp_valid_i,
  input  logic [DATA_W-1:0]  h_rsp_data_i,
  output logic               l_valid_o,
  output logic               l_write_o,
  output logic [LADDR_W-1:0] l_addr_o,
  output logic [DATA_W-1:0]  l_wdata_o,
  input  logic               l_ready_i,
  input  logic               l_rsp_valid_i,
  input  logic [DATA_W-1:0]  l_rsp_data_i,
  output logic               done_o
);
  move_state_e        st_q, st_d;
  logic               dir_q;
  logic [HADDR_W-1:0] haddr_q, haddr_d;
  logic [LADDR_W-1:0] laddr_q, laddr_d;
  logic [WCNT_W-1:0]  left_q, left_d;
  logic [DATA_W-1:0]  dbuf_q;
  logic               src_ready, dst_ready, src_rsp, word_done, dbuf_en;
  logic [DATA_W-1:0]  src_data;

  always_comb begin
    src_ready = dir_q ? l_ready_i     : h_ready_i;
    dst_ready = dir_q ? h_ready_i     : l_ready_i;
    src_rsp   = dir_q ? l_rsp_valid_i : h_rsp_valid_i;
    src_data  = dir_q ? l_rsp_data_i  : h_rsp_data_i;
    word_done = (st_q == MV_WR) && dst_ready;
    dbuf_en   = (st_q == MV_RWAIT) && src_rsp;
    st_d      = st_q;
    haddr_d   = haddr_q;
    laddr_d   = laddr_q;
    left_d    = left_q;
    case (st_q)
      MV_IDLE: if (start_i) begin
        st_d    = (nwords_i == '0) ? MV_IDLE : MV_RD;
        haddr_d = haddr_i;
        laddr_d = laddr_i;
        left_d  = nwords_i;
      end
      MV_RD:    if (src_ready) st_d = MV_RWAIT;
      MV_RWAIT: if (src_rsp)   st_d = MV_WR;
      MV_WR: if (dst_ready) begin
        haddr_d = haddr_q + HADDR_W'(4);
        laddr_d = laddr_q + LADDR_W'(4);
        left_d  = left_q - WCNT_W'(1);
        st_d    = (left_q == WCNT_W'(1)) ? MV_IDLE : MV_RD;
      end
      default: st_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= MV_IDLE;
      haddr_q <= '0;
      laddr_q <= '0;
      left_q  <= '0;
    end else begin
      st_q    <= st_d;
      haddr_q <= haddr_d;
      laddr_q <= laddr_d;
      left_q  <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             dir_q <= 1'b0;
    else if ((st_q == MV_IDLE) && start_i)  dir_q <= dir_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dbuf_q <= '0;
    else if (dbuf_en) dbuf_q <= src_data;
  end

  assign h_valid_o = (!dir_q && (st_q == MV_RD)) || (dir_q && (st_q == MV_WR));
  assign h_write_o = dir_q && (st_q == MV_WR);
  assign h_addr_o  = haddr_q;
  assign h_wdata_o = dbuf_q;
  assign l_valid_o = (dir_q && (st_q == MV_RD)) || (!dir_q && (st_q == MV_WR));
  assign l_write_o = !dir_q && (st_q == MV_WR);
  assign l_addr_o  = laddr_q;
  assign l_wdata_o = dbuf_q;
  assign done_o    = word_done && (left_q == WCNT_W'(1));
endmodule

// File: rtl/dle_dma_seq.sv
module dle_dma_seq
  import dle_dma_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int CNT_W      = 16,
  parameter int ELEM_WORDS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic                 hm_req_valid,
  input  logic                 hm_req_ready,
  output logic                 hm_req_write,
  output logic [HADDR_W-1:0]   hm_req_addr,
  output logic [DATA_W-1:0]    hm_req_wdata,
  input  logic                 hm_rsp_valid,
  input  logic [DATA_W-1:0]    hm_rsp_data,
  output logic                 lb_req_valid,
  input  logic                 lb_req_ready,
  output logic                 lb_req_write,
  output logic [LADDR_W-1:0]   lb_req_addr,
  output logic [DATA_W-1:0]    lb_req_wdata,
  input  logic                 lb_rsp_valid,
  input  logic [DATA_W-1:0]    lb_rsp_data,
  output logic                 qptr_wr_o,
  output logic [PTR_W-1:0]     qptr_val_o,
  output logic                 irq_o,
  output logic                 done_o,
  output logic                 busy_o,
  output logic [IDX_W-1:0]     elem_idx_o,
  output logic [CNT_W-1:0]     remain_o
);
  localparam int WCNT_W = BCNT_W - 1;

  logic [1:0]         rsync_q;
  logic               rst_n_s;
  seq_state_e         st_q, st_d;
  logic               fetch_start, fetch_done, move_start, move_done, retire;
  logic [HADDR_W-1:0] base;
  dle_elem_t          elem;
  logic [BCNT_W:0]    byte_round;
  logic [WCNT_W-1:0]  nwords;
  logic               f_valid;
  logic [HADDR_W-1:0] f_addr;
  logic               m_h_valid, m_h_write;
  logic [HADDR_W-1:0] m_h_addr;
  logic [DATA_W-1:0]  m_h_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  always_comb begin
    byte_round  = {1'b0, elem.bytes} + (BCNT_W+1)'(3);
    nwords      = byte_round[BCNT_W:2];
    fetch_start = (st_q == SEQ_IDLE) && (remain_o != '0);
    move_start  = (st_q == SEQ_FETCH) && fetch_done && (elem.bytes != '0);
    retire      = (st_q == SEQ_RETIRE);
    st_d        = st_q;
    case (st_q)
      SEQ_IDLE:   if (fetch_start) st_d = SEQ_FETCH;
      SEQ_FETCH:  if (fetch_done) st_d = (elem.bytes != '0) ? SEQ_MOVE : SEQ_RETIRE;
      SEQ_MOVE:   if (move_done) st_d = SEQ_RETIRE;
      SEQ_RETIRE: st_d = SEQ_IDLE;
      default:    st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= SEQ_IDLE;
    else          st_q <= st_d;
  end

  dle_ring_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .reg_wr_en_i  (reg_wr_en),
    .reg_addr_i   (reg_addr),
    .reg_wdata_i  (reg_wdata),
    .retire_i     (retire),
    .retire_irq_i (elem.mode[MODE_IRQ]),
    .base_o       (base),
    .idx_o        (elem_idx_o),
    .remain_o     (remain_o),
    .done_o       (done_o),
    .irq_o        (irq_o)
  );

  dle_elem_fetch #(.IDX_W(IDX_W), .ELEM_WORDS(ELEM_WORDS)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (fetch_start),
    .base_i      (base),
    .idx_i       (elem_idx_o),
    .req_valid_o (f_valid),
    .req_addr_o  (f_addr),
    .req_ready_i (hm_req_ready),
    .rsp_valid_i (hm_rsp_valid),
    .rsp_data_i  (hm_rsp_data),
    .elem_o      (elem),
    .done_o      (fetch_done)
  );

  dle_word_mover #(.WCNT_W(WCNT_W)) u_move (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .start_i       (move_start),
    .dir_i         (elem.mode[MODE_DIR]),
    .haddr_i       (elem.haddr),
    .laddr_i       (elem.laddr),
    .nwords_i      (nwords),
    .h_valid_o     (m_h_valid),
    .h_write_o     (m_h_write),
    .h_addr_o      (m_h_addr),
    .h_wdata_o     (m_h_wdata),
    .h_ready_i     (hm_req_ready),
    .h_rsp_valid_i (hm_rsp_valid),
    .h_rsp_data_i  (hm_rsp_data),
    .l_valid_o     (lb_req_valid),
    .l_write_o     (lb_req_write),
    .l_addr_o      (lb_req_addr),
    .l_wdata_o     (lb_req_wdata),
    .l_ready_i     (lb_req_ready),
    .l_rsp_valid_i (lb_rsp_valid),
    .l_rsp_data_i  (lb_rsp_data),
    .done_o        (move_done)
  );

  always_comb begin
    if (st_q == SEQ_FETCH) begin
      hm_req_valid = f_valid;
      hm_req_write = 1'b0;
      hm_req_addr  = f_addr;
      hm_req_wdata = '0;
    end else begin
      hm_req_valid = m_h_valid;
      hm_req_write = m_h_write;
      hm_req_addr  = m_h_addr;
      hm_req_wdata = m_h_wdata;
    end
  end

  assign qptr_wr_o  = retire && !elem.mode[MODE_NOQ];
  assign qptr_val_o = elem.new_ptr;
  assign busy_o     = (st_q != SEQ_IDLE);
endmodule

// File: rtl/dle_dma_seq_chk.sv
module dle_dma_seq_chk #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [1:0]       reg_addr,
  input logic             hm_req_valid,
  input logic             hm_req_ready,
  input logic             hm_req_write,
  input logic [31:0]      hm_req_addr,
  input logic             lb_req_valid,
  input logic             lb_req_ready,
  input logic             lb_req_write,
  input logic [23:0]      lb_req_addr,
  input logic             qptr_wr_o,
  input logic             irq_o,
  input logic             done_o,
  input logic             busy_o,
  input logic [IDX_W-1:0] elem_idx_o,
  input logic [CNT_W-1:0] remain_o
);
  // R11
  hm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hm_req_valid && !hm_req_ready |=> hm_req_valid && $stable(hm_req_addr) && $stable(hm_req_write));

  // R11
  lb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_req_valid && !lb_req_ready |=> lb_req_valid && $stable(lb_req_addr) && $stable(lb_req_write));

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(elem_idx_o) |-> elem_idx_o == $past(elem_idx_o) + IDX_W'(1));

  // R8
  remain_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(remain_o) && !$past(reg_wr_en && (reg_addr == 2'd1))
      |-> remain_o == $past(remain_o) - CNT_W'(1));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o);

  // R5
  qptr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qptr_wr_o |=> !qptr_wr_o);

  // R6
  irq_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !$stable(elem_idx_o));
endmodule

bind dle_dma_seq dle_dma_seq_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_addr     (reg_addr),
  .hm_req_valid (hm_req_valid),
  .hm_req_ready (hm_req_ready),
  .hm_req_write (hm_req_write),
  .hm_req_addr  (hm_req_addr),
  .lb_req_valid (lb_req_valid),
  .lb_req_ready (lb_req_ready),
  .lb_req_write (lb_req_write),
  .lb_req_addr  (lb_req_addr),
  .qptr_wr_o    (qptr_wr_o),
  .irq_o        (irq_o),
  .done_o       (done_o),
  .busy_o       (busy_o),
  .elem_idx_o   (elem_idx_o),
  .remain_o     (remain_o)
);

// File: tb/dle_dma_seq_bench.sv
module dle_dma_seq_bench;
  localparam int MEMW = 4096;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [31:0] haddr;
    logic [23:0] laddr;
    logic [16:0] bytes;
    logic [2:0]  mode;
    logic [15:0] ptr;
    logic [15:0] exp_words;
    logic        exp_q;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h2000, 24'h0100, 17'd16, 3'b000, 16'h0011, 16'd4, 1'b1, 1'b0},
    '{32'h2100, 24'h0200, 17'd5,  3'b010, 16'h0022, 16'd2, 1'b1, 1'b1},
    '{32'h2200, 24'h0300, 17'd0,  3'b010, 16'h0033, 16'd0, 1'b1, 1'b1},
    '{32'h2300, 24'h0400, 17'd12, 3'b100, 16'h1FFF, 16'd3, 1'b1, 1'b0},
    '{32'h2400, 24'h0500, 17'd4,  3'b101, 16'h0044, 16'd1, 1'b0, 1'b0},
    '{32'h2500, 24'h0600, 17'd3,  3'b110, 16'h0055, 16'd1, 1'b1, 1'b1}
  };

  logic        clk, rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        hm_req_valid, hm_req_ready, hm_req_write, hm_rsp_valid;
  logic [31:0] hm_req_addr, hm_req_wdata, hm_rsp_data;
  logic        lb_req_valid, lb_req_ready, lb_req_write, lb_rsp_valid;
  logic [23:0] lb_req_addr;
  logic [31:0] lb_req_wdata, lb_rsp_data;
  logic        qptr_wr_o, irq_o, done_o, busy_o;
  logic [15:0] qptr_val_o, remain_o;
  logic [7:0]  elem_idx_o;

  logic [31:0] hmem [MEMW];
  logic [31:0] lmem [MEMW];
  logic        bd_we;
  logic [11:0] bd_idx;
  logic [31:0] bd_data;
  logic        mem_init;
  int          cyc, qcnt, hwr_cnt, lwr_cnt, lreq_cnt, hdata_cnt;
  logic [15:0] qlast;
  int          vectors, fails;
  logic        finished;

  dle_dma_seq u_dle_dma_seq (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] hpat(input int i);
    return {16'(i) ^ 16'hA5C3, 16'(i)};
  endfunction
  function automatic logic [31:0] lpat(input int i);
    return {16'h3C5A, ~16'(i)};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    hm_req_ready <= ((cyc % 3) != 0);
    lb_req_ready <= ((cyc % 4) != 1);
    if (!mem_init) begin
      for (int i = 0; i < MEMW; i++) begin
        hmem[i] <= hpat(i);
        lmem[i] <= lpat(i);
      end
      mem_init <= 1'b1;
    end else if (bd_we) begin
      hmem[bd_idx] <= bd_data;
    end
    hm_rsp_valid <= 1'b0;
    lb_rsp_valid <= 1'b0;
    if (hm_req_valid && hm_req_ready) begin
      if (hm_req_write) begin
        hmem[hm_req_addr[13:2]] <= hm_req_wdata;
        hwr_cnt <= hwr_cnt + 1;
      end else begin
        hm_rsp_valid <= 1'b1;
        hm_rsp_data  <= hmem[hm_req_addr[13:2]];
        if (hm_req_addr[15:12] != 4'h1) hdata_cnt <= hdata_cnt + 1;
      end
    end
    if (lb_req_valid && lb_req_ready) begin
      lreq_cnt <= lreq_cnt + 1;
      if (lb_req_write) begin
        lmem[lb_req_addr[13:2]] <= lb_req_wdata;
        lwr_cnt <= lwr_cnt + 1;
      end else begin
        lb_rsp_valid <= 1'b1;
        lb_rsp_data  <= lmem[lb_req_addr[13:2]];
      end
    end
    if (qptr_wr_o) begin
      qcnt  <= qcnt + 1;
      qlast <= qptr_val_o;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic bd_write(input int widx, input logic [31:0] d);
    @(negedge clk);
    bd_we   = 1'b1;
    bd_idx  = 12'(widx);
    bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic put_elem(input int slot, input logic [31:0] ha, input logic [23:0] la,
                          input logic [16:0] nb, input logic [2:0] md, input logic [15:0] pt);
    int w0;
    w0 = int'(BASE >> 2) + slot * 4;
    bd_write(w0,     ha);
    bd_write(w0 + 1, {8'h00, la});
    bd_write(w0 + 2, {15'h0, nb});
    bd_write(w0 + 3, {pt, 13'h0, md});
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  initial begin
    vectors = 0; fails = 0; finished = 1'b0;
    cyc = 0; qcnt = 0; qlast = '0; hwr_cnt = 0; lwr_cnt = 0; lreq_cnt = 0; hdata_cnt = 0;
    mem_init = 1'b0; bd_we = 1'b0; bd_idx = '0; bd_data = '0;
    hm_req_ready = 1'b0; lb_req_ready = 1'b0; hm_rsp_valid = 1'b0; lb_rsp_valid = 1'b0;
    hm_rsp_data = '0; lb_rsp_data = '0;
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 busy",   32'(busy_o), 32'd0);
    check("R12 idx",    32'(elem_idx_o), 32'd0);
    check("R12 remain", 32'(remain_o), 32'd0);
    check("R12 irq",    32'(irq_o), 32'd0);
    check("R12 done",   32'(done_o), 32'd0);
    check("R12 req",    32'({hm_req_valid, lb_req_valid}), 32'd0);

    reg_write(2'd0, BASE);
    // R2 zero count leaves block idle
    reg_write(2'd1, 32'd0);
    repeat (4) @(negedge clk);
    check("R2 zero count idle", 32'(busy_o), 32'd0);

    for (int k = 0; k < NVEC; k++) begin
      int q0, hw0, lw0, lr0, hd0, hs, ls;
      put_elem(k, VECS[k].haddr, VECS[k].laddr, VECS[k].bytes, VECS[k].mode, VECS[k].ptr);
      q0 = qcnt; hw0 = hwr_cnt; lw0 = lwr_cnt; lr0 = lreq_cnt; hd0 = hdata_cnt;
      reg_write(2'd1, 32'd1);
      wait_done();
      repeat (2) @(negedge clk);
      hs = int'(VECS[k].haddr >> 2);
      ls = int'(VECS[k].laddr >> 2);
      // R1 element located by index; R8 count and done
      check("R1 R7 idx after element", 32'(elem_idx_o), 32'(k + 1));
      check("R8 remain zero", 32'(remain_o), 32'd0);
      check("R8 idle when done", 32'(busy_o), 32'd0);
      if (VECS[k].mode[2]) begin
        // R4 local to host
        check("R4 host writes", 32'(hwr_cnt - hw0), 32'(VECS[k].exp_words));
        for (int w = 0; w < int'(VECS[k].exp_words); w++)
          check("R4 data", hmem[hs + w], lpat(ls + w));
        check("R4 next word untouched", hmem[hs + int'(VECS[k].exp_words)],
              hpat(hs + int'(VECS[k].exp_words)));
      end else begin
        // R3 host to local; R9 zero bytes gives no request
        check("R3 R9 local writes", 32'(lwr_cnt - lw0), 32'(VECS[k].exp_words));
        for (int w = 0; w < int'(VECS[k].exp_words); w++)
          check("R3 data", lmem[ls + w], hpat(hs + w));
        check("R3 next word untouched", lmem[ls + int'(VECS[k].exp_words)],
              lpat(ls + int'(VECS[k].exp_words)));
      end
      if (VECS[k].bytes == '0)
        check("R9 no data request", 32'((lreq_cnt - lr0) + (hdata_cnt - hd0)), 32'd0);
      // R5 queue pointer update
      check("R5 qptr pulses", 32'(qcnt - q0), 32'(VECS[k].exp_q));
      if (VECS[k].exp_q) check("R5 qptr value", 32'(qlast), 32'(VECS[k].ptr));
      // R6 sticky interrupt
      check("R6 irq", 32'(irq_o), 32'(VECS[k].exp_irq));
      reg_write(2'd2, 32'h3);
      @(negedge clk);
      check("R6 R8 status cleared", 32'({irq_o, done_o}), 32'd0);
    end

    // R10 count added while busy
    begin
      int q0;
      for (int s = 6; s < 9; s++) put_elem(s, 32'h0, 24'h0, 17'd0, 3'b001, 16'hBEEF);
      q0 = qcnt;
      reg_write(2'd1, 32'd1);
      @(negedge clk);
      check("R10 busy before add", 32'(busy_o), 32'd1);
      reg_write(2'd1, 32'd2);
      wait_done();
      @(negedge clk);
      check("R10 idx after add", 32'(elem_idx_o), 32'd9);
      check("R10 remain", 32'(remain_o), 32'd0);
      check("R5 disabled update", 32'(qcnt - q0), 32'd0);
      check("R6 irq stays low", 32'(irq_o), 32'd0);
      reg_write(2'd2, 32'h2);
    end

    // R7 ring wrap
    for (int s = 0; s < 256; s++) put_elem(s, 32'h0, 24'h0, 17'd0, 3'b001, 16'h0);
    reg_write(2'd1, 32'd246);
    wait_done();
    @(negedge clk);
    check("R7 idx 255", 32'(elem_idx_o), 32'd255);
    reg_write(2'd2, 32'h2);
    reg_write(2'd1, 32'd1);
    wait_done();
    @(negedge clk);
    check("R7 idx wrap", 32'(elem_idx_o), 32'd0);
    reg_write(2'd2, 32'h2);
    reg_write(2'd1, 32'd1);
    wait_done();
    @(negedge clk);
    check("R7 idx after wrap", 32'(elem_idx_o), 32'd1);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule